// File: doc/BRIEF.md
# Same-Cycle Pair Dependency Resolver

This block sits at the issue boundary of two in-order integer pipes that issue as a pair. The older instruction goes down pipe X and the younger goes down pipe Y. Each cycle the block receives both decoded instructions. For each one it gets a valid bit, a kind code, a destination register and a source register. It also receives the data words that the pipes present for that group: the cache return for pipe X, the GPR read data for pipe Y, the result of pipe X, and the condition codes produced by both pipes.

When the younger instruction reads the register that the older one writes, the block resolves the dependency inside the group and inserts no stall. There are three ways to do this:

- If the older instruction is a memory load, its cache return is steered into pipe Y.
- If the older instruction is a register-to-register load, pipe Y's GPR read address is redirected to the older instruction's source register.
- If the older instruction sets the condition code and the younger one is a load-and-test of that register onto itself, the younger writeback is dropped and the final condition code is computed from the older result.

Any other dependency raises a split flag, which sends the younger instruction to the next group.

The read address and the split flag are combinational, so the register file and the dispatcher can use them in the same cycle. The routing decision is a registered stream with valid/ready:

- A group is taken when `grp_valid` and `grp_ready` are both high.
- `grp_ready` is high whenever the output slot is empty or is being drained.
- While `res_valid` is high and `res_ready` is low, every registered output holds its value.

Top module: `fwd_pair_resolver`

## Requirements
- R1: After reset, `res_valid` is 0 and `grp_ready` is 1.
- R2: `grp_ready` equals `!res_valid || res_ready`. A group that is taken appears on the registered outputs at the next clock edge with `res_valid` high. While `res_valid` is high and `res_ready` is low, all registered outputs stay stable.
- R3: Kind codes are: 0 ALU (reads src, writes dst, sets CC), 1 memory load (writes dst, reads no GPR), 2 register load (dst <- src), 3 load-and-test (dst <- src, sets CC), 4 store (reads src), 5 no-op. A dependency exists when both instructions are valid, X's kind writes a register, Y's kind reads a register, and `y_src == x_dst`. With no dependency:
  - `y_rd_addr` equals `y_src`.
  - `y_op_src` is 0 and `y_operand` equals `y_gpr_data`.
  - Each writing instruction has its write enable set.
- R4: On a dependency where X is a memory load, `y_op_src` is 1 and `y_operand` equals `x_cache_data`.
- R5: On a dependency where X is a register load, `y_rd_addr` equals `x_src` in the same cycle, and `y_op_src` is 0.
- R6: On a dependency where X sets CC and Y is a load-and-test with `y_dst == y_src`:
  - `y_wr_en` is 0 and `x_wr_en` is 1.
  - `y_op_src` is 2 and `y_operand` equals `x_result`.
  - `cc_out` is derived from `x_result` as 0 for zero, 1 for negative and 2 for positive.
- R7: When both issued instructions write the same register and R6 does not apply, `x_wr_en` is 0 and `y_wr_en` is 1.
- R8: A dependency that matches none of R4, R5 or R6 raises `no_group` combinationally. The registered result then shows:
  - `y_issued` = 0 and `y_wr_en` = 0.
  - `y_op_src` = 3 and `y_operand` = 0.
- R9: The final CC is chosen in this order: the forwarded test (R6), then `y_cc` if Y is issued and sets CC, then `x_cc` if X sets CC. If none applies, `cc_valid` is 0 and `cc_out` is 0.
- R10: If Y is not valid, then `y_issued` = 0, `y_op_src` = 3, `no_group` = 0 and `y_rd_addr` = `y_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | Group presented |
| grp_ready | output | 1 | Group can be taken |
| x_vld | input | 1 | Older instruction valid |
| x_kind | input | 3 | Older kind code |
| x_dst | input | AW | Older destination register |
| x_src | input | AW | Older source register |
| y_vld | input | 1 | Younger instruction valid |
| y_kind | input | 3 | Younger kind code |
| y_dst | input | AW | Younger destination register |
| y_src | input | AW | Younger source register |
| x_cache_data | input | DW | Cache return for pipe X |
| y_gpr_data | input | DW | GPR read data for pipe Y |
| x_result | input | DW | Pipe X result |
| x_cc | input | 2 | CC from pipe X |
| y_cc | input | 2 | CC from pipe Y |
| y_rd_addr | output | AW | GPR read address for pipe Y (combinational) |
| no_group | output | 1 | Younger must split off (combinational) |
| res_valid | output | 1 | Routing result valid |
| res_ready | input | 1 | Consumer takes result |
| y_operand | output | DW | Operand delivered to pipe Y |
| y_op_src | output | 2 | Operand source: 0 GPR, 1 cache, 2 X result, 3 held |
| x_wr_en | output | 1 | Older GPR writeback enable |
| y_wr_en | output | 1 | Younger GPR writeback enable |
| y_issued | output | 1 | Younger executes in this group |
| cc_valid | output | 1 | Final CC is produced |
| cc_out | output | 2 | Final condition code |

## Verification
Directed pairs come first. There is one pair for each of the three forwarding patterns, plus a load-and-test whose destination differs from its source, which must split rather than forward. A same-destination pair without a dependency shows that the older write is dropped and not the younger one. Zero, negative and positive X results tell the three forwarded CC values apart. Random pairs then follow, drawn from a four-register window so that dependencies and collisions are frequent, and mixed with `res_ready` stalls so that output holding is exercised alongside every pattern.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [2:0] {
    K_ALU = 3'd0,
    K_LDM = 3'd1,
    K_LDR = 3'd2,
    K_LTR = 3'd3,
    K_STO = 3'd4,
    K_NOP = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    SRC_GPR   = 2'd0,
    SRC_CACHE = 2'd1,
    SRC_XRES  = 2'd2,
    SRC_HELD  = 2'd3
  } opsrc_e;

  typedef enum logic [1:0] {
    CCS_NONE = 2'd0,
    CCS_X    = 2'd1,
    CCS_Y    = 2'd2,
    CCS_TEST = 2'd3
  } ccsel_e;

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == K_ALU) || (k == K_LDM) || (k == K_LDR) || (k == K_LTR);
  endfunction

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == K_ALU) || (k == K_LDR) || (k == K_LTR) || (k == K_STO);
  endfunction

  function automatic logic kind_sets_cc(input logic [2:0] k);
    return (k == K_ALU) || (k == K_LTR);
  endfunction

endpackage

// File: rtl/fwd_dep_detect.sv
module fwd_dep_detect
  import fwd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          x_vld,
  input  logic [2:0]    x_kind,
  input  logic [AW-1:0] x_dst,
  input  logic [AW-1:0] x_src,
  input  logic          y_vld,
  input  logic [2:0]    y_kind,
  input  logic [AW-1:0] y_dst,
  input  logic [AW-1:0] y_src,
  output logic [AW-1:0] y_rd_addr,
  output logic          no_group,
  output logic          y_go,
  output logic          x_we,
  output logic          y_we,
  output opsrc_e        op_sel,
  output ccsel_e        cc_sel
);

  logic x_wr, y_wr, y_rd, dep;
  logic pat_mem, pat_reg, pat_cc, collide;

  always_comb begin
    x_wr    = x_vld && kind_writes(x_kind);
    y_wr    = y_vld && kind_writes(y_kind);
    y_rd    = y_vld && kind_reads(y_kind);
    dep     = x_wr && y_rd && (y_src == x_dst);
    pat_mem = dep && (x_kind == K_LDM);
    pat_reg = dep && (x_kind == K_LDR);
    pat_cc  = dep && kind_sets_cc(x_kind) && (y_kind == K_LTR) && (y_dst == y_src);
    no_group = dep && !(pat_mem || pat_reg || pat_cc);
    y_go    = y_vld && !no_group;
    collide = x_wr && y_go && y_wr && (x_dst == y_dst) && !pat_cc;
    x_we    = x_wr && !collide;
    y_we    = y_go && y_wr && !pat_cc;
    y_rd_addr = pat_reg ? x_src : y_src;

    if (!y_go)        op_sel = SRC_HELD;
    else if (pat_mem) op_sel = SRC_CACHE;
    else if (pat_cc)  op_sel = SRC_XRES;
    else              op_sel = SRC_GPR;

    if (pat_cc)                                cc_sel = CCS_TEST;
    else if (y_go && kind_sets_cc(y_kind))     cc_sel = CCS_Y;
    else if (x_vld && kind_sets_cc(x_kind))    cc_sel = CCS_X;
    else                                       cc_sel = CCS_NONE;
  end

endmodule

// File: rtl/fwd_cc_eval.sv
module fwd_cc_eval #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] value,
  output logic [1:0]    cc
);

  always_comb begin
    if (value == '0)       cc = 2'd0;
    else if (value[DW-1])  cc = 2'd1;
    else                   cc = 2'd2;
  end

endmodule

// File: rtl/fwd_out_stage.sv
module fwd_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fwd_pair_resolver.sv
module fwd_pair_resolver
  import fwd_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_valid,
  output logic          grp_ready,
  input  logic          x_vld,
  input  logic [2:0]    x_kind,
  input  logic [AW-1:0] x_dst,
  input  logic [AW-1:0] x_src,
  input  logic          y_vld,
  input  logic [2:0]    y_kind,
  input  logic [AW-1:0] y_dst,
  input  logic [AW-1:0] y_src,
  input  logic [DW-1:0] x_cache_data,
  input  logic [DW-1:0] y_gpr_data,
  input  logic [DW-1:0] x_result,
  input  logic [1:0]    x_cc,
  input  logic [1:0]    y_cc,
  output logic [AW-1:0] y_rd_addr,
  output logic          no_group,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] y_operand,
  output logic [1:0]    y_op_src,
  output logic          x_wr_en,
  output logic          y_wr_en,
  output logic          y_issued,
  output logic          cc_valid,
  output logic [1:0]    cc_out
);

  localparam int PW = DW + 8;

  logic   y_go, x_we, y_we;
  opsrc_e op_sel;
  ccsel_e cc_sel;
  logic [1:0]    test_cc;
  logic [DW-1:0] opnd;
  logic [1:0]    cc_n;
  logic          ccv_n;
  logic [PW-1:0] pk_d, pk_q;

  fwd_dep_detect #(.AW(AW)) u_det (
    .x_vld(x_vld), .x_kind(x_kind), .x_dst(x_dst), .x_src(x_src),
    .y_vld(y_vld), .y_kind(y_kind), .y_dst(y_dst), .y_src(y_src),
    .y_rd_addr(y_rd_addr), .no_group(no_group), .y_go(y_go),
    .x_we(x_we), .y_we(y_we), .op_sel(op_sel), .cc_sel(cc_sel)
  );

  fwd_cc_eval #(.DW(DW)) u_cc (.value(x_result), .cc(test_cc));

  always_comb begin
    unique case (op_sel)
      SRC_GPR:   opnd = y_gpr_data;
      SRC_CACHE: opnd = x_cache_data;
      SRC_XRES:  opnd = x_result;
      default:   opnd = '0;
    endcase
    ccv_n = (cc_sel != CCS_NONE);
    unique case (cc_sel)
      CCS_TEST: cc_n = test_cc;
      CCS_Y:    cc_n = y_cc;
      CCS_X:    cc_n = x_cc;
      default:  cc_n = 2'd0;
    endcase
    pk_d = {opnd, op_sel, x_we, y_we, y_go, ccv_n, cc_n};
  end

  fwd_out_stage #(.W(PW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(grp_valid), .in_ready(grp_ready), .d(pk_d),
    .out_valid(res_valid), .out_ready(res_ready), .q(pk_q)
  );

  assign {y_operand, y_op_src, x_wr_en, y_wr_en, y_issued, cc_valid, cc_out} = pk_q;

endmodule

// File: rtl/fwd_pair_resolver_chk.sv
module fwd_pair_resolver_chk #(
  parameter int DW = 64,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grp_valid,
  input logic          grp_ready,
  input logic          x_vld,
  input logic [2:0]    x_kind,
  input logic [AW-1:0] x_src,
  input logic          y_vld,
  input logic [AW-1:0] y_src,
  input logic [AW-1:0] y_rd_addr,
  input logic          no_group,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] y_operand,
  input logic [1:0]    y_op_src,
  input logic          y_wr_en,
  input logic          y_issued,
  input logic          cc_valid,
  input logic [1:0]    cc_out
);

  assert_take_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready) |=> res_valid);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(y_operand) && $stable(y_op_src)
                                    && $stable(cc_out) && $stable(y_wr_en)));

  assert_redirect_only_reg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (y_rd_addr != y_src) |-> (x_vld && x_kind == 3'd2 && y_rd_addr == x_src));

  assert_split_blocks_y_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready && no_group) |=> (!y_issued && !y_wr_en && y_op_src == 2'd3));

  assert_no_split_without_y_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !y_vld |-> !no_group);

  assert_cc_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cc_valid) |-> (cc_out != 2'd3 || y_op_src != 2'd2));

  assert_held_means_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && y_issued) |-> (y_op_src != 2'd3));

endmodule

bind fwd_pair_resolver fwd_pair_resolver_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
  .x_vld(x_vld), .x_kind(x_kind), .x_src(x_src), .y_vld(y_vld), .y_src(y_src),
  .y_rd_addr(y_rd_addr), .no_group(no_group), .res_valid(res_valid),
  .res_ready(res_ready), .y_operand(y_operand), .y_op_src(y_op_src),
  .y_wr_en(y_wr_en), .y_issued(y_issued), .cc_valid(cc_valid), .cc_out(cc_out)
);

// File: tb/fwd_pair_resolver_test.sv
module fwd_pair_resolver_test;

  localparam int DW = 64;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic grp_valid = 0, res_ready = 1;
  logic x_vld = 0, y_vld = 0;
  logic [2:0] x_kind = 3'd5, y_kind = 3'd5;
  logic [AW-1:0] x_dst = 0, x_src = 0, y_dst = 0, y_src = 0;
  logic [DW-1:0] x_cache_data = 0, y_gpr_data = 0, x_result = 0;
  logic [1:0] x_cc = 0, y_cc = 0;
  logic grp_ready, no_group, res_valid, x_wr_en, y_wr_en, y_issued, cc_valid;
  logic [AW-1:0] y_rd_addr;
  logic [DW-1:0] y_operand;
  logic [1:0] y_op_src, cc_out;

  fwd_pair_resolver #(.DW(DW), .AW(AW)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic          m_valid = 0;
  logic [DW-1:0] m_opnd;
  logic [1:0]    m_src, m_cc;
  logic          m_xwe, m_ywe, m_yiss, m_ccv;
  string         m_tag = "R3";

  // combinational expectations
  logic [AW-1:0] c_rd;
  logic          c_split;
  logic [DW-1:0] c_opnd;
  logic [1:0]    c_src, c_cc;
  logic          c_xwe, c_ywe, c_yiss, c_ccv;
  string         c_tag;

  function automatic bit wr(input logic [2:0] k); return k <= 3; endfunction
  function automatic bit rd(input logic [2:0] k); return k == 0 || k == 2 || k == 3 || k == 4; endfunction
  function automatic bit scc(input logic [2:0] k); return k == 0 || k == 3; endfunction

  task automatic model();
    bit dep, f_mem, f_reg, f_cc;
    dep   = x_vld && wr(x_kind) && y_vld && rd(y_kind) && y_src == x_dst;
    f_mem = dep && x_kind == 1;
    f_reg = dep && x_kind == 2;
    f_cc  = dep && scc(x_kind) && y_kind == 3 && y_dst == y_src;
    c_split = dep && !f_mem && !f_reg && !f_cc;
    c_yiss  = y_vld && !c_split;
    c_rd    = f_reg ? x_src : y_src;
    c_tag   = "R3";
    c_opnd  = y_gpr_data; c_src = 0;
    if (!c_yiss) begin c_opnd = 0; c_src = 3; c_tag = y_vld ? "R8" : "R10"; end
    else if (f_mem) begin c_opnd = x_cache_data; c_src = 1; c_tag = "R4"; end
    else if (f_cc) begin c_opnd = x_result; c_src = 2; c_tag = "R6"; end
    else if (f_reg) c_tag = "R5";
    c_xwe = x_vld && wr(x_kind);
    c_ywe = c_yiss && wr(y_kind) && !f_cc;
    if (c_ywe && c_xwe && x_dst == y_dst) begin c_xwe = 0; if (c_tag == "R3") c_tag = "R7"; end
    c_ccv = 1;
    if (f_cc) begin
      if (x_result == 0) c_cc = 0;
      else if ($signed(x_result) < 0) c_cc = 1;
      else c_cc = 2;
    end else if (c_yiss && scc(y_kind)) c_cc = y_cc;
    else if (x_vld && scc(x_kind)) c_cc = x_cc;
    else begin c_ccv = 0; c_cc = 0; if (c_tag == "R3") c_tag = "R9"; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_valid <= 0;
    else if (grp_valid && (!m_valid || res_ready)) begin
      model();
      m_valid <= 1; m_opnd <= c_opnd; m_src <= c_src; m_xwe <= c_xwe; m_ywe <= c_ywe;
      m_yiss <= c_yiss; m_ccv <= c_ccv; m_cc <= c_cc; m_tag <= c_tag;
    end else if (res_ready) m_valid <= 0;
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs();
    chk("R2", "res_valid", 64'(res_valid), 64'(m_valid));
    if (m_valid) begin
      chk(m_tag, "y_operand", y_operand, m_opnd);
      chk(m_tag, "y_op_src", 64'(y_op_src), 64'(m_src));
      chk(m_tag, "x_wr_en", 64'(x_wr_en), 64'(m_xwe));
      chk(m_tag, "y_wr_en", 64'(y_wr_en), 64'(m_ywe));
      chk(m_tag, "y_issued", 64'(y_issued), 64'(m_yiss));
      chk(m_tag, "cc_valid", 64'(cc_valid), 64'(m_ccv));
      chk(m_tag, "cc_out", 64'(cc_out), 64'(m_cc));
    end
  endtask

  task automatic drive(input logic xv, input logic [2:0] xk, input int xd, input int xs,
                       input logic yv, input logic [2:0] yk, input int yd, input int ys,
                       input logic [DW-1:0] xres, input logic rr);
    @(negedge clk);
    check_regs();
    grp_valid = 1; res_ready = rr;
    x_vld = xv; x_kind = xk; x_dst = AW'(xd); x_src = AW'(xs);
    y_vld = yv; y_kind = yk; y_dst = AW'(yd); y_src = AW'(ys);
    x_cache_data = {$urandom, $urandom}; y_gpr_data = {$urandom, $urandom};
    x_result = xres; x_cc = 2'($urandom); y_cc = 2'($urandom);
    #1;
    model();
    chk(c_tag, "y_rd_addr", 64'(y_rd_addr), 64'(c_rd));
    chk(y_vld ? "R8" : "R10", "no_group", 64'(no_group), 64'(c_split));
    chk("R2", "grp_ready", 64'(grp_ready), 64'(!m_valid || res_ready));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "res_valid after reset", 64'(res_valid), 64'd0);
    chk("R1", "grp_ready after reset", 64'(grp_ready), 64'd1);
    rst_n = 1;
    drive(1, 0, 1, 2, 1, 0, 3, 4, 64'd7, 1);          // R3 independent
    drive(1, 1, 5, 0, 1, 0, 5, 5, 64'd0, 1);          // R4 mem forward, R7 same dst
    drive(1, 2, 6, 9, 1, 4, 0, 6, 64'd0, 1);          // R5 redirect
    drive(1, 0, 2, 2, 1, 3, 2, 2, 64'd0, 1);          // R6 zero
    drive(1, 0, 2, 2, 1, 3, 2, 2, 64'h8000_0000_0000_0001, 1); // R6 negative
    drive(1, 3, 2, 1, 1, 3, 2, 2, 64'd42, 1);         // R6 positive
    drive(1, 0, 2, 2, 1, 3, 7, 2, 64'd3, 1);          // R8 LTR dst != src
    drive(1, 0, 4, 1, 1, 1, 4, 0, 64'd3, 1);          // R7 collision, no dep
    drive(1, 4, 0, 1, 1, 4, 0, 2, 64'd3, 1);          // R9 no CC setter
    drive(1, 0, 1, 2, 0, 0, 1, 1, 64'd3, 1);          // R10 Y invalid
    drive(1, 1, 3, 0, 1, 0, 8, 8, 64'd1, 0);          // R2 stall
    drive(1, 0, 1, 1, 1, 0, 2, 2, 64'd1, 0);
    drive(1, 0, 1, 1, 1, 0, 2, 2, 64'd1, 1);
    for (int i = 0; i < 400; i++) begin
      logic [DW-1:0] r;
      r = ($urandom % 4 == 0) ? 64'd0 : {$urandom, $urandom};
      drive(1'($urandom % 8 != 0), 3'($urandom % 6), $urandom % 4, $urandom % 4,
            1'($urandom % 8 != 0), 3'($urandom % 6), $urandom % 4, $urandom % 4,
            r, 1'($urandom % 4 != 0));
    end
    @(negedge clk);
    grp_valid = 0; res_ready = 1;
    check_regs();
    @(negedge clk);
    check_regs();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule